// File: doc/BRIEF.md
# Sector-Compressed Fully Associative Translation Buffer

This block is a first-level address translation array for single-stage, non-virtualized paging with Sv39 widths. It is fully associative with 48 entries. One entry can pack up to eight neighbouring 4 KB translations. The eight translations share a tag, which is the virtual page number with its three low bits removed. They also share the upper physical page bits and the permission bits. Each of the eight keeps its own 3-bit low physical page field and its own valid flag. Pages of 2 MB and 1 GB, and 64 KB contiguous-page entries, are kept uncompressed in the same array. Any entry can hold any page size.

Each cycle the block takes at most one lookup, made of a virtual address and an address-space identifier. It returns a registered answer one cycle later: a valid flag, a miss flag, the physical address and the entry's permission bits. A page-walk response port writes one new entry per cycle and presents the whole group of eight neighbouring PTEs. A lookup that falls on the entry being written in the same cycle is answered from the write data. A tree pseudo-LRU picks the entry to replace, and an empty entry is always taken first. A flush input invalidates the whole array.

Top module: `sector_tlb`

## Requirements
- R1: Timing of the answer:
  - A lookup with `req_valid` high in cycle N produces `resp_valid` high in cycle N+1.
  - `resp_valid` is low in every cycle that follows a cycle without a lookup.
- R2: A 4 KB compressed hit needs three things: a matching tag, a matching ASID, and a set valid flag for slot `vpn[2:0]`. On such a hit:
  - The PPN is the shared upper PPN followed by that slot's 3-bit low PPN.
  - `resp_pa` is the PPN followed by the 12-bit page offset.
  - `resp_perm` is the shared permission byte.
- R3: On a 4 KB refill, slot i (i = 0..7 of `rf_ppn`/`rf_perm`/`rf_pte_ok`, where slot i holds bits [i*W +: W]) is valid only if all of the following hold:
  - its PTE-ok bit is set;
  - its PPN bits above bit 2 equal those of the requested slot `rf_vpn[2:0]`;
  - its permission byte equals that of the requested slot.
  A lookup to an invalid slot misses.
- R4: A lookup whose ASID differs from the stored ASID misses.
- R5: Superpages, selected by `rf_level`:
  - 2 MB pages (`rf_level`=1) compare VPN[26:9] only, and 1 GB pages (`rf_level`=2) compare VPN[26:18] only.
  - The output PPN takes its low 9 (for 2 MB) or 18 (for 1 GB) bits from the request VPN.
- R6: A 64 KB contiguous entry (`rf_napot`=1 with `rf_level`=0) ignores VPN[3:0] in the compare and does not consult the slot valid flags. The low 4 PPN bits of the output come from the request VPN.
- R7: A lookup in the same cycle as a refill that writes the entry it would hit is answered from the refill data, and it hits.
- R8: Flushing:
  - A cycle with `flush` high invalidates every entry by the next cycle.
  - A refill presented in the same cycle as a flush is discarded.
- R9: While any entry is invalid, a refill is written to the lowest-numbered invalid entry, so 48 distinct refills after a flush all remain resident.
- R10: Replacement when the array is full:
  - Tree pseudo-LRU state is updated by every hit and every refill.
  - With all entries valid, after hits to entries 1..47 in ascending order, the next refill replaces entry 0.
- R11: After reset all entries are invalid and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 39 | Virtual address of the lookup |
| req_asid | input | 16 | Address-space identifier of the lookup |
| resp_valid | output | 1 | Answer present (one cycle after request) |
| resp_miss | output | 1 | Answer is a miss |
| resp_pa | output | 56 | Physical address (PPN and page offset) |
| resp_perm | output | 8 | Permission byte of the hit entry |
| rf_valid | input | 1 | Refill write present |
| rf_vpn | input | 27 | VPN of the requested translation |
| rf_asid | input | 16 | ASID stored with the refill |
| rf_level | input | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rf_napot | input | 1 | Entry covers 16 contiguous 4 KB pages |
| rf_ppn | input | 352 | Eight PPNs, slot i at [i*44 +: 44] |
| rf_perm | input | 64 | Eight permission bytes, slot i at [i*8 +: 8] |
| rf_pte_ok | input | 8 | Per-slot PTE usable flag |
| flush | input | 1 | Invalidate all entries |

## Verification
Two functions of this block can act in the same cycle, and the bench makes both cases happen.

The first case is a refill and a lookup of the address being refilled. The bench drives both on the same falling edge into an array with empty entries. It expects a hit carrying the refill's physical address in the next cycle, and it repeats the lookup afterwards against the stored copy.

The second case is a flush and a refill arriving together. A later lookup of the refilled page must miss.

Replacement is judged by filling the whole array after a flush and touching every entry except entry 0. The next refill must displace exactly entry 0, while the other entries still hit.

// File: rtl/sector_tlb_pkg.sv
package sector_tlb_pkg;

    parameter int unsigned VA_W       = 39;
    parameter int unsigned OFF_W      = 12;
    parameter int unsigned VPN_W      = VA_W - OFF_W;
    parameter int unsigned PPN_W      = 44;
    parameter int unsigned PA_W       = PPN_W + OFF_W;
    parameter int unsigned ASID_W     = 16;
    parameter int unsigned PERM_W     = 8;
    parameter int unsigned SLOTS      = 8;
    parameter int unsigned SLOT_W     = $clog2(SLOTS);
    parameter int unsigned TAG_W      = VPN_W - SLOT_W;
    parameter int unsigned HI_W       = PPN_W - SLOT_W;
    parameter int unsigned LVL_BITS   = 9;
    parameter int unsigned NAPOT_BITS = 4;

    typedef enum logic [1:0] {
        LVL_4K = 2'd0,
        LVL_2M = 2'd1,
        LVL_1G = 2'd2
    } lvl_e;

    typedef struct packed {
        logic [TAG_W-1:0]             tag;
        logic [ASID_W-1:0]            asid;
        lvl_e                         lvl;
        logic                         napot;
        logic [HI_W-1:0]              ppn_hi;
        logic [PERM_W-1:0]            perm;
        logic [SLOTS-1:0]             slot_vld;
        logic [SLOTS-1:0]             req_oh;
        logic [SLOTS-1:0][SLOT_W-1:0] ppn_lo;
    } entry_t;

    typedef struct packed {
        logic              hit;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } match_t;

    // Tag bits that take part in the compare for a given page kind.
    function automatic logic [TAG_W-1:0] tag_cmp_mask(input lvl_e lvl, input logic napot);
        logic [TAG_W-1:0] m;
        case (lvl)
            LVL_2M:  m = {TAG_W{1'b1}} << (LVL_BITS - SLOT_W);
            LVL_1G:  m = {TAG_W{1'b1}} << (2 * LVL_BITS - SLOT_W);
            default: m = napot ? ({TAG_W{1'b1}} << (NAPOT_BITS - SLOT_W)) : {TAG_W{1'b1}};
        endcase
        return m;
    endfunction

    // PPN bits that are replaced by the request VPN.
    function automatic logic [PPN_W-1:0] ppn_pass_mask(input lvl_e lvl, input logic napot);
        logic [PPN_W-1:0] m;
        case (lvl)
            LVL_2M:  m = ~({PPN_W{1'b1}} << LVL_BITS);
            LVL_1G:  m = ~({PPN_W{1'b1}} << (2 * LVL_BITS));
            default: m = napot ? ~({PPN_W{1'b1}} << NAPOT_BITS) : '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sector_tlb_fill.sv
module sector_tlb_fill
    import sector_tlb_pkg::*;
(
    input  logic [VPN_W-1:0]        rf_vpn,
    input  logic [ASID_W-1:0]       rf_asid,
    input  logic [1:0]              rf_level,
    input  logic                    rf_napot,
    input  logic [SLOTS*PPN_W-1:0]  rf_ppn,
    input  logic [SLOTS*PERM_W-1:0] rf_perm,
    input  logic [SLOTS-1:0]        rf_pte_ok,
    output entry_t                  fill_ent,
    output logic                    fill_ok
);
    logic [SLOT_W-1:0] req_slot;
    logic [PPN_W-1:0]  ref_ppn;
    logic [PERM_W-1:0] ref_perm;
    logic              packed_mode;

    assign req_slot    = rf_vpn[SLOT_W-1:0];
    assign ref_ppn     = rf_ppn[int'(req_slot)*PPN_W +: PPN_W];
    assign ref_perm    = rf_perm[int'(req_slot)*PERM_W +: PERM_W];
    assign packed_mode = (lvl_e'(rf_level) == LVL_4K) && !rf_napot;
    assign fill_ok     = rf_pte_ok[req_slot];

    always_comb begin
        fill_ent        = '0;
        fill_ent.tag    = rf_vpn[VPN_W-1:SLOT_W];
        fill_ent.asid   = rf_asid;
        fill_ent.lvl    = lvl_e'(rf_level);
        fill_ent.napot  = rf_napot;
        fill_ent.ppn_hi = ref_ppn[PPN_W-1:SLOT_W];
        fill_ent.perm   = ref_perm;
        fill_ent.req_oh = SLOTS'(1) << req_slot;
        for (int i = 0; i < SLOTS; i++) begin
            logic [PPN_W-1:0]  p;
            logic [PERM_W-1:0] a;
            p = rf_ppn[i*PPN_W +: PPN_W];
            a = rf_perm[i*PERM_W +: PERM_W];
            if (packed_mode) begin
                fill_ent.slot_vld[i] = rf_pte_ok[i]
                                     && (p[PPN_W-1:SLOT_W] == ref_ppn[PPN_W-1:SLOT_W])
                                     && (a == ref_perm);
                fill_ent.ppn_lo[i]   = p[SLOT_W-1:0];
            end else begin
                fill_ent.slot_vld[i] = 1'b1;
                fill_ent.ppn_lo[i]   = ref_ppn[SLOT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sector_tlb_way.sv
module sector_tlb_way
    import sector_tlb_pkg::*;
(
    input  logic              vld,
    input  entry_t            ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output match_t            res
);
    logic [SLOT_W-1:0] slot;
    logic [TAG_W-1:0]  cmp_mask;
    logic [PPN_W-1:0]  pass_mask;
    logic [SLOT_W-1:0] lo;
    logic [PPN_W-1:0]  ppn_raw;
    logic              tag_ok;
    logic              slot_ok;

    assign slot      = vpn[SLOT_W-1:0];
    assign cmp_mask  = tag_cmp_mask(ent.lvl, ent.napot);
    assign pass_mask = ppn_pass_mask(ent.lvl, ent.napot);
    assign tag_ok    = ((ent.tag ^ vpn[VPN_W-1:SLOT_W]) & cmp_mask) == '0;
    assign slot_ok   = ent.napot || ent.slot_vld[slot];

    always_comb begin
        lo = ent.ppn_lo[slot];
        if (ent.napot) begin
            lo = '0;
            for (int i = 0; i < SLOTS; i++) begin
                if (ent.req_oh[i]) lo = lo | ent.ppn_lo[i];
            end
        end
    end

    assign ppn_raw  = {ent.ppn_hi, lo};
    assign res.hit  = vld && tag_ok && slot_ok && (ent.asid == asid);
    assign res.ppn  = (ppn_raw & ~pass_mask) | ({{(PPN_W-VPN_W){1'b0}}, vpn} & pass_mask);
    assign res.perm = ent.perm;

endmodule

// File: rtl/sector_tlb_plru.sv
module sector_tlb_plru #(
    parameter int unsigned ENTRIES = 48,
    localparam int unsigned LG     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned NP     = 1 << LG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] vld,
    input  logic               hit_en,
    input  logic [LG-1:0]      hit_idx,
    input  logic               fill_en,
    input  logic [LG-1:0]      fill_idx,
    output logic [LG-1:0]      victim
);
    // Nodes whose right subtree holds no real entry always point left.
    function automatic logic [NP-1:1] force_left();
        logic [NP-1:1] m = '0;
        for (int d = 0; d < LG; d++) begin
            for (int k = 0; k < (1 << d); k++) begin
                int span = NP >> d;
                if (k * span + span / 2 >= ENTRIES) m[(1 << d) + k] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [NP-1:1] FORCE_L = force_left();

    function automatic logic [NP-1:1] touch(input logic [NP-1:1] t, input logic [LG-1:0] idx);
        logic [NP-1:1] r = t;
        for (int d = 0; d < LG; d++) begin
            int node = (NP + int'(idx)) >> (LG - d);
            r[node] = !idx[LG-1-d];
        end
        return r & ~FORCE_L;
    endfunction

    function automatic logic [LG-1:0] walk(input logic [NP-1:1] t);
        int n = 1;
        for (int d = 0; d < LG; d++) n = 2 * n + int'(t[n]);
        return LG'(n - NP);
    endfunction

    logic [NP-1:1] tree_q, tree_d;
    logic [LG-1:0] free_idx;
    logic          any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = LG'(i);
                any_free = 1'b1;
            end
        end
    end

    assign victim = any_free ? free_idx : walk(tree_q);

    always_comb begin
        tree_d = tree_q;
        if (hit_en)  tree_d = touch(tree_d, hit_idx);
        if (fill_en) tree_d = touch(tree_d, fill_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

endmodule

// File: rtl/sector_tlb.sv
module sector_tlb
    import sector_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 48,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_va,
    input  logic [ASID_W-1:0]       req_asid,
    output logic                    resp_valid,
    output logic                    resp_miss,
    output logic [PA_W-1:0]         resp_pa,
    output logic [PERM_W-1:0]       resp_perm,
    input  logic                    rf_valid,
    input  logic [VPN_W-1:0]        rf_vpn,
    input  logic [ASID_W-1:0]       rf_asid,
    input  logic [1:0]              rf_level,
    input  logic                    rf_napot,
    input  logic [SLOTS*PPN_W-1:0]  rf_ppn,
    input  logic [SLOTS*PERM_W-1:0] rf_perm,
    input  logic [SLOTS-1:0]        rf_pte_ok,
    input  logic                    flush
);
    entry_t             ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    entry_t             fill_ent;
    logic               fill_ok;
    logic               wr_en;
    logic [IDX_W-1:0]   victim;
    logic [VPN_W-1:0]   req_vpn;
    match_t             m [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [PPN_W-1:0]   hit_ppn;
    logic [PERM_W-1:0]  hit_perm;

    assign req_vpn = req_va[VA_W-1:OFF_W];
    assign wr_en   = rf_valid && !flush && fill_ok;

    sector_tlb_fill u_fill (
        .rf_vpn    (rf_vpn),
        .rf_asid   (rf_asid),
        .rf_level  (rf_level),
        .rf_napot  (rf_napot),
        .rf_ppn    (rf_ppn),
        .rf_perm   (rf_perm),
        .rf_pte_ok (rf_pte_ok),
        .fill_ent  (fill_ent),
        .fill_ok   (fill_ok)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
        logic   byp;
        entry_t ent_eff;
        logic   vld_eff;
        assign byp     = wr_en && (victim == IDX_W'(g));
        assign ent_eff = byp ? fill_ent : ent_q[g];
        assign vld_eff = byp || vld_q[g];
        sector_tlb_way u_way (
            .vld  (vld_eff),
            .ent  (ent_eff),
            .vpn  (req_vpn),
            .asid (req_asid),
            .res  (m[g])
        );
        assign hit_vec[g] = m[g].hit;
    end

    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        hit_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (m[i].hit) begin
                hit_ppn  = hit_ppn | m[i].ppn;
                hit_perm = hit_perm | m[i].perm;
                hit_idx  = IDX_W'(i);
            end
        end
    end

    assign hit_any = |hit_vec;

    sector_tlb_plru #(.ENTRIES(ENTRIES)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .vld      (vld_q),
        .hit_en   (req_valid && hit_any),
        .hit_idx  (hit_idx),
        .fill_en  (wr_en),
        .fill_idx (victim),
        .victim   (victim)
    );

    always_ff @(posedge clk) begin
        if (rst)        vld_q <= '0;
        else if (flush) vld_q <= '0;
        else if (wr_en) vld_q[victim] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_q[victim] <= fill_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_miss  <= 1'b0;
            resp_pa    <= '0;
            resp_perm  <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_miss  <= !hit_any;
            resp_pa    <= {hit_ppn, req_va[OFF_W-1:0]};
            resp_perm  <= hit_perm;
        end
    end

endmodule

// File: rtl/sector_tlb_chk.sv
module sector_tlb_chk #(
    parameter int unsigned ENTRIES = 48,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               resp_valid,
    input logic               flush,
    input logic               wr_en,
    input logic [ENTRIES-1:0] vld_q,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [IDX_W-1:0]   victim
);
    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R1
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

    // R9
    victim_free_chk: assert property (@(posedge clk) disable iff (rst)
        !(&vld_q) |-> !vld_q[victim]);

    // R10
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        victim < IDX_W'(ENTRIES));

    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(victim)]);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!resp_valid && (vld_q == '0)));

endmodule

bind sector_tlb sector_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .resp_valid (resp_valid),
    .flush      (flush),
    .wr_en      (wr_en),
    .vld_q      (vld_q),
    .hit_vec    (hit_vec),
    .victim     (victim)
);

// File: tb/tb_sector_tlb.sv
module tb_sector_tlb;
    import sector_tlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 48;
    localparam int NV         = 14;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic [VA_W-1:0]         req_va = '0;
    logic [ASID_W-1:0]       req_asid = '0;
    logic                    resp_valid, resp_miss;
    logic [PA_W-1:0]         resp_pa;
    logic [PERM_W-1:0]       resp_perm;
    logic                    rf_valid = 1'b0;
    logic [VPN_W-1:0]        rf_vpn = '0;
    logic [ASID_W-1:0]       rf_asid = '0;
    logic [1:0]              rf_level = '0;
    logic                    rf_napot = 1'b0;
    logic [SLOTS*PPN_W-1:0]  rf_ppn = '0;
    logic [SLOTS*PERM_W-1:0] rf_perm = '0;
    logic [SLOTS-1:0]        rf_pte_ok = '0;
    logic                    flush = 1'b0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_tlb #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
        .resp_valid(resp_valid), .resp_miss(resp_miss), .resp_pa(resp_pa), .resp_perm(resp_perm),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_level(rf_level),
        .rf_napot(rf_napot), .rf_ppn(rf_ppn), .rf_perm(rf_perm), .rf_pte_ok(rf_pte_ok),
        .flush(flush)
    );

    // {req id 4, vpn 27, offset 12, asid 16, miss 1, ppn 44, perm 8}
    localparam logic [111:0] VECS [NV] = '{
        {4'd2,  27'h0001230, 12'hABC, 16'h5, 1'b0, 44'h0000ABC00, 8'h0F}, // R2 slot 0
        {4'd2,  27'h0001231, 12'h010, 16'h5, 1'b0, 44'h0000ABC01, 8'h0F}, // R2 slot 1
        {4'd2,  27'h0001234, 12'hFFF, 16'h5, 1'b0, 44'h0000ABC04, 8'h0F}, // R2 requested slot
        {4'd3,  27'h0001232, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}, // R3 upper PPN differs
        {4'd3,  27'h0001235, 12'h123, 16'h5, 1'b0, 44'h0000ABC05, 8'h0F}, // R3 matching slot kept
        {4'd3,  27'h0001236, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}, // R3 permission differs
        {4'd3,  27'h0001237, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}, // R3 PTE not ok
        {4'd4,  27'h0001234, 12'h000, 16'h6, 1'b1, 44'h0,         8'h00}, // R4 other ASID
        {4'd5,  27'h0040355, 12'h444, 16'h5, 1'b0, 44'h000123555, 8'h07}, // R5 2 MB
        {4'd5,  27'h0040400, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}, // R5 2 MB neighbour
        {4'd5,  27'h00C2A5B7,12'h321, 16'h5, 1'b0, 44'h00802A5B7, 8'h03}, // R5 1 GB
        {4'd5,  27'h0D00000, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}, // R5 1 GB neighbour
        {4'd6,  27'h000567D, 12'h0AA, 16'h5, 1'b0, 44'h00777777D, 8'h0F}, // R6 contiguous
        {4'd6,  27'h0005680, 12'h000, 16'h5, 1'b1, 44'h0,         8'h00}  // R6 next block
    };

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [SLOTS*PPN_W-1:0] mk_ppns(input logic [PPN_W-1:0] base);
        logic [SLOTS*PPN_W-1:0] r;
        for (int i = 0; i < SLOTS; i++) r[i*PPN_W +: PPN_W] = base + PPN_W'(i);
        return r;
    endfunction

    function automatic logic [SLOTS*PERM_W-1:0] mk_perms(input logic [PERM_W-1:0] p);
        return {SLOTS{p}};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_refill(input logic [VPN_W-1:0] vpn, input logic [1:0] lvl, input logic napot,
                              input logic [SLOTS*PPN_W-1:0] ppns, input logic [SLOTS*PERM_W-1:0] perms,
                              input logic [SLOTS-1:0] ok);
        rf_valid = 1'b1; rf_vpn = vpn; rf_asid = 16'h5; rf_level = lvl;
        rf_napot = napot; rf_ppn = ppns; rf_perm = perms; rf_pte_ok = ok;
    endtask

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [1:0] lvl, input logic napot,
                          input logic [SLOTS*PPN_W-1:0] ppns, input logic [SLOTS*PERM_W-1:0] perms,
                          input logic [SLOTS-1:0] ok);
        @(negedge clk);
        set_refill(vpn, lvl, napot, ppns, perms, ok);
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off, input logic [ASID_W-1:0] asid);
        @(negedge clk);
        req_valid = 1'b1; req_va = {vpn, off}; req_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [SLOTS*PPN_W-1:0]  pa_set;
        logic [SLOTS*PERM_W-1:0] pm_set;
        int bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: no answer after reset, and the array is empty
        chk("R11", 64'(resp_valid), 64'd0);
        lookup(27'h0001230, 12'h0, 16'h5);
        chk("R11", 64'(resp_miss), 64'd1);
        // R1: answer one cycle after request, idle after
        chk("R1", 64'(resp_valid), 64'd1);
        @(negedge clk);
        chk("R1", 64'(resp_valid), 64'd0);

        // Compressed group: slot 2 upper differs, slot 6 perm differs, slot 7 not ok
        pa_set = mk_ppns(44'h0000ABC00);
        pa_set[2*PPN_W +: PPN_W] = 44'h0000DDD02;
        pm_set = mk_perms(8'h0F);
        pm_set[6*PERM_W +: PERM_W] = 8'h0B;
        refill(27'h0001234, 2'd0, 1'b0, pa_set, pm_set, 8'h7F);
        refill(27'h0040200, 2'd1, 1'b0, mk_ppns(44'h000123400), mk_perms(8'h07), 8'hFF);
        refill(27'h0C00000, 2'd2, 1'b0, mk_ppns(44'h008000000), mk_perms(8'h03), 8'hFF);
        refill(27'h0005670, 2'd0, 1'b1, mk_ppns(44'h007777778), mk_perms(8'h0F), 8'hFF);

        for (int k = 0; k < NV; k++) begin
            logic [111:0] v;
            v = VECS[k];
            lookup(v[107:81], v[80:69], v[68:53]);
            chk(req_name(v[111:108]), 64'(resp_miss), 64'(v[52]));
            if (!v[52]) begin
                chk(req_name(v[111:108]), 64'(resp_pa), 64'({v[51:8], v[80:69]}));
                chk(req_name(v[111:108]), 64'(resp_perm), 64'(v[7:0]));
            end
        end

        // R8: flush empties the array
        do_flush();
        lookup(27'h0001230, 12'h0, 16'h5);
        chk("R8", 64'(resp_miss), 64'd1);

        // R8: refill in the flush cycle is dropped
        @(negedge clk);
        flush = 1'b1;
        set_refill(27'h0333330, 2'd0, 1'b0, mk_ppns(44'h000444400), mk_perms(8'h0F), 8'hFF);
        @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0;
        lookup(27'h0333330, 12'h0, 16'h5);
        chk("R8", 64'(resp_miss), 64'd1);

        // R7: refill and lookup of the same page in one cycle
        @(negedge clk);
        set_refill(27'h0444440, 2'd0, 1'b0, mk_ppns(44'h000555500), mk_perms(8'h0F), 8'hFF);
        req_valid = 1'b1; req_va = {27'h0444443, 12'h123}; req_asid = 16'h5;
        @(negedge clk);
        rf_valid = 1'b0; req_valid = 1'b0;
        chk("R7", 64'(resp_miss), 64'd0);
        chk("R7", 64'(resp_pa), 64'({44'h000555503, 12'h123}));
        lookup(27'h0444443, 12'h123, 16'h5);
        chk("R7", 64'(resp_pa), 64'({44'h000555503, 12'h123}));

        // R9: 48 distinct refills after a flush all stay resident
        do_flush();
        for (int k = 0; k < ENTRIES; k++)
            refill(27'h0100000 + VPN_W'(k * 8), 2'd0, 1'b0,
                   mk_ppns(44'h2000 + PPN_W'(k * 8)), mk_perms(8'h0F), 8'hFF);
        bad = 0;
        for (int k = 0; k < ENTRIES; k++) begin
            lookup(27'h0100000 + VPN_W'(k * 8 + 3), 12'h0, 16'h5);
            if (resp_miss || resp_pa != {44'h2000 + PPN_W'(k * 8 + 3), 12'h0}) bad++;
        end
        chk("R9", 64'(bad), 64'd0);

        // R10: ascending hits leave entry 0 as the replacement choice
        refill(27'h0200000, 2'd0, 1'b0, mk_ppns(44'h9000), mk_perms(8'h0F), 8'hFF);
        lookup(27'h0100000, 12'h0, 16'h5);
        chk("R10", 64'(resp_miss), 64'd1);
        lookup(27'h0100000 + VPN_W'(47 * 8), 12'h0, 16'h5);
        chk("R10", 64'(resp_miss), 64'd0);
        lookup(27'h0100008, 12'h0, 16'h5);
        chk("R10", 64'(resp_miss), 64'd0);
        lookup(27'h0200001, 12'h0, 16'h5);
        chk("R10", 64'(resp_pa), 64'({44'h9001, 12'h0}));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule